// File: doc/BRIEF.md
# PCI Target Claim Timing Unit

This unit decides, for one PCI interface of a bridge, whether a transaction on the initiating bus is claimed, and on which clock DEVSEL# is driven. It watches FRAME#, IRDY#, TRDY# and the C/BE# command lines. It also takes one-bit hit results from external address comparators: a normal memory window, an I/O window, a configuration decode and a special memory window. A separate enable qualifies the special window.

Normal hits are claimed with medium decode timing. A memory hit inside the enabled special window is always claimed with slow timing. Both timings stay inside the five-clock claim deadline. Once claimed, DEVSEL# is held until the last data phase completes. The unit then drives DEVSEL# high for one clock and releases the line. The pad driver combines `devsel_no` with `devsel_oe_o`.

Top module: `pci_target_claim`

## Requirements
- R1: After reset, and whenever the line is not driven, `devsel_oe_o` is 0 and `devsel_no` is 1.
- R2: The address edge is the rising edge at which `frame_ni` is sampled 0 after being sampled 1 at the previous edge. A normal hit is claimed with medium timing: `devsel_no` goes 0 and `devsel_oe_o` goes 1 on the 2nd rising edge after the address edge.
- R3: A memory command is slow-claimed when the special-window hit and the special-window enable are both 1. Slow claiming means DEVSEL# is asserted on the 3rd rising edge after the address edge. This holds even when the normal memory hit is also 1.
- R4: With the special-window enable at 0, the special-window hit has no effect. A memory command is then claimed, with medium timing, only when the normal memory hit is 1.
- R5: The command code selects which hit input counts:
  - memory commands (0110, 0111, 1100, 1110, 1111) use the memory and special hits;
  - I/O commands (0010, 0011) use the I/O hit;
  - configuration commands (1010, 1011) use the configuration hit;
  - every other code is never claimed;
  - a hit of a class other than the command's class is ignored.
- R6: The command, the hit inputs and the special-window enable are sampled only at the address edge. Later changes during the transaction do not change the claim or its timing.
- R7: Once asserted, `devsel_no` stays 0 until an edge where `frame_ni` is 1 while `irdy_ni` and `trdy_ni` are both 0. This includes final-phase wait states where `trdy_ni` is still 1.
- R8: At that ending edge `devsel_no` returns to 1 with `devsel_oe_o` still 1. At the next edge `devsel_oe_o` returns to 0.
- R9: A transaction that is not claimed never sets `devsel_oe_o`.
- R10: Either timing asserts DEVSEL# no later than the 5th rising edge after the address edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PCI clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | 1 | FRAME#, active low |
| irdy_ni | input | 1 | IRDY#, active low |
| trdy_ni | input | 1 | TRDY# as seen on the bus, active low |
| cmd_i | input | 4 | C/BE# lines, holding the command in the address phase |
| mem_hit_i | input | 1 | Normal memory window hit |
| io_hit_i | input | 1 | I/O window hit |
| cfg_hit_i | input | 1 | Configuration decode hit |
| spc_hit_i | input | 1 | Special memory window hit |
| spc_en_i | input | 1 | Special memory window enable |
| devsel_no | output | 1 | DEVSEL# output value, active low |
| devsel_oe_o | output | 1 | DEVSEL# output enable |

## Verification
The bench builds the unit with its default parameters: medium delay 2, slow delay 3 and deadline 5. With these values the one-clock gap between the two timings is visible on every claim, and the slow claim sits two clocks inside the deadline. After the address edge the bench inverts the command, the hit inputs and the enable. Any late sampling therefore shows up as a wrong claim or wrong timing. Final-phase target wait states exercise the hold-until-completion rule separately from FRAME# deassertion.

// File: rtl/pci_claim_pkg.sv
package pci_claim_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {CLS_NONE, CLS_MEM, CLS_IO, CLS_CFG} cmd_cls_e;
  typedef enum logic [2:0] {ST_IDLE, ST_DECODE, ST_CLAIM, ST_TURN, ST_SKIP} claim_st_e;

  typedef struct packed {
    logic mem;
    logic io;
    logic cfg;
    logic spc;
    logic spc_en;
  } hit_t;

  function automatic cmd_cls_e classify(input logic [CMD_W-1:0] c);
    case (c)
      4'h2, 4'h3:                         return CLS_IO;
      4'h6, 4'h7, 4'hC, 4'hE, 4'hF:       return CLS_MEM;
      4'hA, 4'hB:                         return CLS_CFG;
      default:                            return CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pci_claim_decode.sv
module pci_claim_decode
  import pci_claim_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  input  hit_t             hit_i,
  output logic             claim_o,
  output logic             slow_o
);
  cmd_cls_e cls;

  always_comb begin
    cls     = classify(cmd_i);
    claim_o = 1'b0;
    slow_o  = 1'b0;
    case (cls)
      CLS_MEM: begin
        // enabled special window wins over the normal window and forces slow
        if (hit_i.spc && hit_i.spc_en) begin
          claim_o = 1'b1;
          slow_o  = 1'b1;
        end else begin
          claim_o = hit_i.mem;
        end
      end
      CLS_IO:  claim_o = hit_i.io;
      CLS_CFG: claim_o = hit_i.cfg;
      default: claim_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pci_claim_seq.sv
module pci_claim_seq
  import pci_claim_pkg::*;
#(
  parameter int MED_DLY  = 2,
  parameter int SLOW_DLY = 3,
  parameter int MAX_DLY  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             trdy_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  hit_t             hit_i,
  output logic             set_o,
  output logic             rel_o,
  output logic             off_o
);
  localparam int CNT_W = $clog2(MAX_DLY + 1) + 1;
  localparam logic [CNT_W-1:0] MED_C  = CNT_W'(MED_DLY);
  localparam logic [CNT_W-1:0] SLOW_C = CNT_W'(SLOW_DLY);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_DLY);

  claim_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] cmd_q;
  hit_t             hit_q;
  logic             frame_q;
  logic             claim, slow, start, last_done;
  logic [CNT_W-1:0] tgt;

  pci_claim_decode u_dec (
    .cmd_i   (cmd_q),
    .hit_i   (hit_q),
    .claim_o (claim),
    .slow_o  (slow)
  );

  assign tgt       = slow ? SLOW_C : MED_C;
  assign start     = (st_q == ST_IDLE) && !frame_ni && frame_q;
  assign last_done = frame_ni && !irdy_ni && !trdy_ni;
  assign set_o     = (st_q == ST_DECODE) && claim && (cnt_q == tgt);
  assign rel_o     = (st_q == ST_CLAIM) && last_done;
  assign off_o     = (st_q == ST_TURN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      hit_q   <= '0;
      frame_q <= 1'b1;
    end else begin
      frame_q <= frame_ni;
      case (st_q)
        ST_IDLE: if (start) begin
          cmd_q <= cmd_i;
          hit_q <= hit_i;
          cnt_q <= CNT_W'(1);
          st_q  <= ST_DECODE;
        end
        ST_DECODE: begin
          if (!claim)              st_q <= ST_SKIP;
          else if (cnt_q == tgt)   st_q <= ST_CLAIM;
          else                     cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_CLAIM: if (last_done) st_q <= ST_TURN;
        ST_TURN:  st_q <= ST_IDLE;
        ST_SKIP:  if (frame_ni && irdy_ni) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: claim must land inside the deadline window
  p_deadline_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECODE) |-> (cnt_q <= MAX_C));
  // R2/R3: the decision never flips mid-decode since inputs are latched (R6)
  p_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DECODE && $past(st_q) == ST_DECODE) |-> $stable(claim) && $stable(slow));
endmodule

// File: rtl/pci_devsel_drv.sv
module pci_devsel_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rel_i,
  input  logic off_i,
  output logic devsel_no,
  output logic devsel_oe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      devsel_no   <= 1'b1;
      devsel_oe_o <= 1'b0;
    end else if (set_i) begin
      devsel_no   <= 1'b0;
      devsel_oe_o <= 1'b1;
    end else if (rel_i) begin
      devsel_no   <= 1'b1;
    end else if (off_i) begin
      devsel_oe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pci_target_claim.sv
module pci_target_claim
  import pci_claim_pkg::*;
#(
  parameter int MED_DLY  = 2,
  parameter int SLOW_DLY = 3,
  parameter int MAX_DLY  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             trdy_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             mem_hit_i,
  input  logic             io_hit_i,
  input  logic             cfg_hit_i,
  input  logic             spc_hit_i,
  input  logic             spc_en_i,
  output logic             devsel_no,
  output logic             devsel_oe_o
);
  hit_t hit;
  logic set, rel, off;

  assign hit = '{mem: mem_hit_i, io: io_hit_i, cfg: cfg_hit_i,
                 spc: spc_hit_i, spc_en: spc_en_i};

  pci_claim_seq #(
    .MED_DLY  (MED_DLY),
    .SLOW_DLY (SLOW_DLY),
    .MAX_DLY  (MAX_DLY)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .irdy_ni  (irdy_ni),
    .trdy_ni  (trdy_ni),
    .cmd_i    (cmd_i),
    .hit_i    (hit),
    .set_o    (set),
    .rel_o    (rel),
    .off_o    (off)
  );

  pci_devsel_drv u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set),
    .rel_i       (rel),
    .off_i       (off),
    .devsel_no   (devsel_no),
    .devsel_oe_o (devsel_oe_o)
  );

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!devsel_no && !frame_ni) |=> !devsel_no);
  p_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!devsel_no && frame_ni && !irdy_ni && !trdy_ni) |=> devsel_no && devsel_oe_o);
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (devsel_oe_o && devsel_no) |=> !devsel_oe_o);
  p_undriven_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !devsel_oe_o |-> devsel_no);
  p_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_seq.st_q == ST_SKIP) |-> !devsel_oe_o);
endmodule

// File: tb/test_pci_target_claim.sv
module test_pci_target_claim;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [3:0] cmd = 4'h0;
  logic       mh = 0, ih = 0, ch = 0, sh = 0, en = 0;
  logic       devsel_n, devsel_oe;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  pci_target_claim i_pci_target_claim (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .trdy_ni(trdy_n), .cmd_i(cmd), .mem_hit_i(mh), .io_hit_i(ih),
    .cfg_hit_i(ch), .spc_hit_i(sh), .spc_en_i(en),
    .devsel_no(devsel_n), .devsel_oe_o(devsel_oe)
  );

  task automatic chk(input logic e_oe, input logic e_dev, input string rq, input int k);
    checks++;
    if (devsel_oe !== e_oe || devsel_n !== e_dev) begin
      failures++;
      $display("FAIL %s edge %0d: oe=%b devsel_n=%b expected oe=%b devsel_n=%b",
               rq, k, devsel_oe, devsel_n, e_oe, e_dev);
    end
  endtask

  // behavioural reference: claim class and delay from the requirements
  task automatic txn(input logic [3:0] c, input logic m, i, g, s, e,
                     input int hold, input int tws, input string rq);
    bit is_mem, is_io, is_cfg, claim;
    int d, f, r;
    string tag;
    is_mem = (c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF);
    is_io  = (c == 4'h2 || c == 4'h3);
    is_cfg = (c == 4'hA || c == 4'hB);
    d = 2;
    if (is_mem && s && e) begin claim = 1; d = 3; end
    else if (is_mem) claim = m;
    else if (is_io)  claim = i;
    else if (is_cfg) claim = g;
    else claim = 0;
    f = claim ? d + hold : 6;
    r = claim ? f + tws : f;
    @(negedge clk);
    frame_n = 0; irdy_n = 1; trdy_n = 1;
    cmd = c; mh = m; ih = i; ch = g; sh = s; en = e;
    for (int k = 0; k <= r + 2; k++) begin
      int nx;
      @(posedge clk);
      @(negedge clk);
      if (!claim || k < d || k > r) begin
        tag = claim ? rq : {rq, " R9"};
        chk(1'b0, 1'b1, tag, k);
      end else if (k < r) chk(1'b1, 1'b0, {rq, " R7"}, k);
      else                chk(1'b1, 1'b1, "R8", k);
      // R6: scramble sampled inputs after the address edge
      nx = k + 1;
      cmd = ~c; mh = ~m; ih = ~i; ch = ~g; sh = ~s; en = ~e;
      frame_n = (nx >= f);
      irdy_n  = !(nx <= r);
      trdy_n  = !(claim && nx > d && nx <= r && !(nx >= f && nx < f + tws));
    end
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          failures++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(1'b0, 1'b1, "R1", 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(1'b0, 1'b1, "R1", 0);
    txn(4'h6, 1, 0, 0, 0, 0, 2, 0, "R2 mem medium");
    txn(4'h3, 0, 1, 0, 0, 0, 1, 0, "R2 R5 io medium");
    txn(4'hA, 0, 0, 1, 0, 0, 3, 0, "R5 cfg medium");
    txn(4'h7, 0, 0, 0, 1, 1, 2, 0, "R3 R10 special slow");
    txn(4'hF, 1, 0, 0, 1, 1, 1, 1, "R3 R10 special beats normal");
    txn(4'h6, 0, 0, 0, 1, 0, 2, 0, "R4 special disabled miss");
    txn(4'h7, 1, 0, 0, 1, 0, 2, 0, "R4 special disabled medium");
    txn(4'h2, 1, 0, 1, 1, 1, 2, 0, "R5 io with foreign hits");
    txn(4'h0, 1, 1, 1, 1, 1, 2, 0, "R5 unclaimable code");
    txn(4'hB, 0, 1, 0, 0, 0, 2, 0, "R5 cfg with io hit");
    txn(4'hC, 1, 0, 0, 0, 1, 4, 2, "R7 final-phase wait states");
    txn(4'hE, 0, 0, 0, 1, 1, 3, 3, "R6 R3 scrambled inputs");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule